// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block runs single read or write transactions on the two-wire PHY management bus. A host raises `req` for one clock with a read/write flag, a 5-bit register number and, for writes, a 16-bit value. The block then builds the whole serial frame. The PHY address comes from a parameter. The block divides the system clock down to produce MDC, and it controls the shared data line through a data output and an output-enable.

Every frame opens with a long run of ones. A start pattern, the opcode and both addresses follow. A write frame ends with a driven turnaround and the data word. A read frame ends with a released line, one unsampled turnaround slot and sixteen sampled data bits. When the frame ends, `done` pulses for one clock, and after a read the received word appears on `rd_data`. The block handles only one transaction at a time. Requests that arrive while a frame is running are dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0x0000. Whenever `busy` is 0, `mdc` and `mdio_oe` are both 0.
- R2: Each frame starts with 34 slots that carry 1, followed by a start pattern of 0 and then 1.
- R3: Next comes the opcode, which is 1,0 for a read and 0,1 for a write. Then the PHY address (parameter `PHY_ADDR`, default 1) and the register number are sent, 5 bits each, MSB first.
- R4: Each bit slot lasts 3×`PHASE_CLKS` system clocks. MDC is low for the first `PHASE_CLKS` clocks, high for the next `PHASE_CLKS` clocks and low again for the last `PHASE_CLKS` clocks. `mdio_o` changes only at slot boundaries and never while MDC is high.
- R5: A write frame has 66 slots and drives all of them. After the addresses it sends turnaround 1,0 and then the 16 data bits, MSB first.
- R6: A read frame has 65 slots. `mdio_oe` is 1 only for the first 48 slots. Slot 48 is a turnaround that is not sampled. Slots 49 to 64 are sampled on the last clock of the MDC-high phase, MSB first. The resulting word is on `rd_data` from the `done` cycle onward.
- R7: `busy` is 1 for exactly 3×`PHASE_CLKS`×(number of slots) clocks, starting the clock after the request is accepted. `done` is a one-clock pulse in the first clock after `busy` falls.
- R8: A request made while `busy` is 1 is ignored. It does not change the running frame and does not start a frame later.
- R9: A request made in the clock where `done` pulses is accepted, and `busy` is 1 in the next clock.
- R10: A write frame leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transaction (taken only when idle) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rd_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
Two things can happen in the same clock. One is the end of a frame, when `done` pulses and `busy` falls. The other is a new request. The bench waits for the `done` cycle and raises `req` in that same cycle. It then checks that `busy` is high in the next clock, and that the scoreboard finds both frames complete, with the right slot contents, length and read word. As a counter-case, a request raised in the middle of a frame must leave that frame's bits unchanged and must not produce an extra frame or `done` pulse.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W         = 5;
  localparam int DATA_W         = 16;
  localparam int PRE_BITS       = 34;
  localparam int HDR_BITS       = 4 + 2 * ADDR_W;
  localparam int FRAME_BITS     = PRE_BITS + HDR_BITS + 2 + DATA_W;
  localparam int RD_DRIVE_SLOTS = PRE_BITS + HDR_BITS;
  localparam int RD_FIRST_SAMP  = RD_DRIVE_SLOTS + 1;
  localparam int RD_SLOTS       = RD_FIRST_SAMP + DATA_W;
  localparam int WR_SLOTS       = FRAME_BITS;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_HIGH  = 2'd1,
    PH_HOLD  = 2'd2
  } mdc_phase_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rega,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    op  = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b00 : 2'b10;
    dat = rd ? '0 : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, rega, ta, dat};
  endfunction
endpackage

// File: rtl/mdc_phase_gen.sv
module mdc_phase_gen #(
  parameter int PHASE_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic slot_end,
  output logic sample_pt
);
  import mdio_pkg::*;

  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;
  mdc_phase_e    ph;
  logic          ph_end;

  assign ph_end    = run && (cnt == CNT_LAST);
  assign slot_end  = ph_end && (ph == PH_HOLD);
  assign sample_pt = ph_end && (ph == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      ph  <= PH_SETUP;
      mdc <= 1'b0;
    end else if (ph_end) begin
      cnt <= '0;
      case (ph)
        PH_SETUP: begin ph <= PH_HIGH; mdc <= 1'b1; end
        PH_HIGH:  begin ph <= PH_HOLD; mdc <= 1'b0; end
        default:  begin ph <= PH_SETUP; mdc <= 1'b0; end
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_mdc_only_high_phase_r4: assert property (@(posedge clk) disable iff (rst)
    mdc |-> (ph == PH_HIGH));
  p_mdc_low_when_stopped_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx #(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        load_rd,
  input  logic [4:0]  load_reg,
  input  logic [15:0] load_wdata,
  input  logic        shift,
  output logic        mdio_o
);
  import mdio_pkg::*;

  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= build_frame(load_rd, PHY_ADDR, load_reg, load_wdata);
    end else if (shift) begin
      shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign mdio_o = shreg[FRAME_BITS-1];

  p_preamble_first_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> mdio_o);
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          sample_en,
  input  logic          mdio_i,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word <= '0;
    end else if (sample_en) begin
      word <= {word[DW-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int         PHASE_CLKS = 4,
  parameter logic [4:0] PHY_ADDR   = 5'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        req_rd,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  localparam int SLOT_W = $clog2(FRAME_BITS + 1);

  logic              accept;
  logic              is_rd;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_nx;
  logic [SLOT_W-1:0] last_slot;
  logic [SLOT_W-1:0] drive_slots;
  logic              slot_end;
  logic              sample_pt;
  logic              sample_en;
  logic [15:0]       rx_word;

  assign accept      = req && !busy;
  assign slot_nx     = slot + 1'b1;
  assign last_slot   = is_rd ? SLOT_W'(RD_SLOTS - 1) : SLOT_W'(WR_SLOTS - 1);
  assign drive_slots = is_rd ? SLOT_W'(RD_DRIVE_SLOTS) : SLOT_W'(WR_SLOTS);
  assign sample_en   = busy && is_rd && sample_pt && (slot >= SLOT_W'(RD_FIRST_SAMP));

  mdc_phase_gen #(.PHASE_CLKS(PHASE_CLKS)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .mdc       (mdc),
    .slot_end  (slot_end),
    .sample_pt (sample_pt)
  );

  mdio_frame_tx #(.PHY_ADDR(PHY_ADDR)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_rd    (req_rd),
    .load_reg   (req_reg),
    .load_wdata (req_wdata),
    .shift      (busy && slot_end),
    .mdio_o     (mdio_o)
  );

  mdio_frame_rx #(.DW(16)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .sample_en (sample_en),
    .mdio_i    (mdio_i),
    .word      (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_oe <= 1'b0;
      is_rd   <= 1'b0;
      slot    <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        is_rd   <= req_rd;
        slot    <= '0;
        mdio_oe <= 1'b1;
      end else if (busy && slot_end) begin
        if (slot == last_slot) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          mdio_oe <= 1'b0;
          if (is_rd) rd_data <= rx_word;
        end else begin
          slot    <= slot_nx;
          mdio_oe <= (slot_nx < drive_slots);
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc));
  p_data_steady_high_r4: assert property (@(posedge clk) disable iff (rst)
    mdc |-> $stable(mdio_o));
  p_read_released_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && slot >= SLOT_W'(RD_DRIVE_SLOTS)) |-> !mdio_oe);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && req && !slot_end) |=> (busy && $stable(is_rd)));
  p_write_keeps_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !is_rd) |-> $stable(rd_data));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_rd = 1'b0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.PHASE_CLKS(P), .PHY_ADDR(5'd1)) dut (
    .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic        rd;
    logic [65:0] bits;
    int          nd;
    int          nslots;
    logic [15:0] rdat;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, ndone = 0;
  logic [15:0] last_rd = 16'h0000;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Driver: call at a negedge; pushes expectation only when the request will be taken.
  task automatic issue(input logic rd, input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] rdat);
    exp_t e;
    req = 1'b1; req_rd = rd; req_reg = rg; req_wdata = wd;
    if (!busy) begin
      e.rd     = rd;
      e.bits   = {34'h3_FFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 5'd1, rg,
                  (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : wd)};
      e.nd     = rd ? 48 : 66;
      e.nslots = rd ? 65 : 66;
      e.rdat   = rdat;
      q.push_back(e);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || busy);
  endtask

  // Monitor and PHY model
  logic [65:0] cap;
  int ncap, nrise, hcnt, terr, bcnt;
  logic prev_mdc, hi_val;

  always @(negedge clk) begin
    if (rst) begin
      cap = '0; ncap = 0; nrise = 0; hcnt = 0; terr = 0; bcnt = 0;
      prev_mdc = 1'b0; hi_val = 1'b0;
    end else begin
      if (busy) bcnt++;
      if (mdc && !prev_mdc) begin
        nrise++;
        hi_val = mdio_o;
        hcnt = 1;
        if (mdio_oe) begin cap = {cap[64:0], mdio_o}; ncap++; end
      end else if (mdc) begin
        hcnt++;
        if (mdio_o !== hi_val) terr++;
      end else if (!mdc && prev_mdc) begin
        if (hcnt != P) terr++;
        if (q.size() != 0 && q[0].rd && nrise - 1 >= 48 && nrise - 1 <= 63)
          mdio_i = q[0].rdat[63 - (nrise - 1)];
        else
          mdio_i = 1'b1;
      end
      prev_mdc = mdc;
      if (done) begin
        ndone++;
        if (q.size() == 0) begin
          chk(0, "R8 unexpected frame", 66'(ndone), 66'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cap[65:0] == (e.bits >> (66 - e.nd)), "R2/R3/R5 frame bits",
              cap, e.bits >> (66 - e.nd));
          chk(ncap == e.nd, e.rd ? "R6 driven slots" : "R5 driven slots", 66'(ncap), 66'(e.nd));
          chk(nrise == e.nslots && terr == 0, "R4 slot timing", 66'(nrise), 66'(e.nslots));
          chk(bcnt == e.nslots * 3 * P, "R7 busy length", 66'(bcnt), 66'(e.nslots * 3 * P));
          if (e.rd) begin
            chk(rd_data == e.rdat, "R6 read word", 66'(rd_data), 66'(e.rdat));
            last_rd = e.rdat;
          end else begin
            chk(rd_data == last_rd, "R10 rd_data kept", 66'(rd_data), 66'(last_rd));
          end
        end
        cap = '0; ncap = 0; nrise = 0; terr = 0; bcnt = 0; mdio_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 66'(0), 66'(1));
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 66'(0));
    chk(mdc == 0 && mdio_oe == 0, "R1 mdc/oe", {mdc, mdio_oe}, 66'(0));
    chk(rd_data == 16'h0000, "R1 rd_data", 66'(rd_data), 66'(0));

    issue(1'b0, 5'h00, 16'hA5C3, 16'h0); wait_idle();
    issue(1'b1, 5'h11, 16'h0000, 16'h8001); wait_idle();
    issue(1'b0, 5'h1F, 16'hFFFF, 16'h0); wait_idle();
    issue(1'b1, 5'h01, 16'h0000, 16'h3C5A); wait_idle();

    // R8: request while busy is ignored
    issue(1'b0, 5'h10, 16'h1234, 16'h0);
    repeat (100) @(negedge clk);
    issue(1'b1, 5'h05, 16'hBEEF, 16'hFFFF);
    wait_idle();
    repeat (3 * P * 70) @(negedge clk);
    chk(busy == 0 && ndone == 5, "R8 no extra frame", 66'(ndone), 66'(5));

    // R9: request in the done cycle
    issue(1'b1, 5'h02, 16'h0000, 16'h7E81);
    do @(negedge clk); while (!done);
    issue(1'b0, 5'h1A, 16'h0F0F, 16'h0);
    chk(busy == 1, "R9 back-to-back accept", 66'(busy), 66'(1));
    wait_idle();
    chk(ndone == 7, "R9 frame count", 66'(ndone), 66'(7));
    chk(mdio_oe == 0 && mdc == 0, "R1 idle lines", {mdio_oe, mdc}, 66'(0));
    finish_run();
  end
endmodule